// File: doc/BRIEF.md
# DMA protected high-memory window filter

This block decides whether an incoming DMA address lands inside a protected region of high system memory. Software programs a start register and an end register through a small register port, then turns protection on through a control register. While protection is active, every DMA address presented with a valid strobe is compared against the window. One cycle later a blocked flag reports whether the access must be refused.

Both window registers are 64 bits wide, but only a 1 MiB-granular field below the host address width is stored. The start is taken as the first byte of its 1 MiB block and the end as the last byte of its 1 MiB block. An end value below the start value turns the window off. The window registers are frozen while protection is active. A capability input can declare the high region unsupported, and the window registers then keep their reset value.

Top module: `hm_guard`

## Requirements
- R1: After reset the control, start and end registers read as zero, and the blocked output is low.
- R2: Only bits 38:20 of the start register (offset 0x10-0x08 = 0x08) and of the end register (offset 0x10) can be written. All other bits read back as zero.
- R3: The control register at offset 0x00 holds the enable in bit 0. Its bit 1 reads the protection status, which takes the enable value one cycle after the enable register is updated.
- R4: Writes to the start or end register have no effect while the protection status is set.
- R5: While capHigh is low, writes to the start and end registers have no effect.
- R6: dmaBlocked is high in the cycle after a dmaValid cycle exactly when all three of these hold:
  - the status is set;
  - the start field is at most the end field;
  - {start field, 20 zero bits} ≤ dmaAddr[38:0] ≤ {end field, 20 one bits}.
  Address bits 63:39 are ignored.
- R7: When the end field is below the start field, no address is blocked, even with protection on.
- R8: When the start and end fields are equal, the window covers exactly 1 MiB, starting at the start address.
- R9: dmaBlocked is low in any cycle that does not follow a dmaValid cycle.
- R10: Reads of any other offset return zero, and writes to other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Single-cycle register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Register read data for regAddr (combinational) |
| capHigh | input | 1 | High region supported; low makes the window registers read-only |
| dmaValid | input | 1 | DMA address strobe |
| dmaAddr | input | 64 | DMA address to check |
| dmaBlocked | output | 1 | Registered block decision for the previous strobe |

## Verification
The bench builds the block with its default parameters: a 39-bit host address width and 20 hard-wired low bits. With these values, real 1 MiB block edges and the ignored bits above bit 38 are reachable with plain 64-bit constants. A vector table sweeps addresses just below, at and just past both window edges, including one with the upper address bits set. Directed tests cover these cases:
- the status delay;
- the write freeze;
- the capability lock;
- an inverted window;
- a single 1 MiB window.

// File: rtl/hm_guard_pkg.sv
package hm_guard_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned OFS_W  = 8;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_START = 8'h08;
  localparam logic [OFS_W-1:0] OFS_END   = 8'h10;

  typedef struct packed {
    logic wrStart;
    logic wrEnd;
  } hmStrobe_t;
endpackage

// File: rtl/hm_guard_ctrl.sv
module hm_guard_ctrl
  import hm_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [OFS_W-1:0] regAddr,
  input  logic             wrBit0,
  input  logic             capHigh,
  output hmStrobe_t        strb,
  output logic             enableQ,
  output logic             statusQ
);
  logic winWritable;

  // Window registers accept writes only when supported and not protecting.
  assign winWritable = capHigh && !statusQ;

  always_comb begin
    strb.wrStart = regWe && winWritable && (regAddr == OFS_START);
    strb.wrEnd   = regWe && winWritable && (regAddr == OFS_END);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      statusQ <= 1'b0;
    end else begin
      if (regWe && regAddr == OFS_CTRL) enableQ <= wrBit0;
      statusQ <= enableQ;
    end
  end
endmodule

// File: rtl/hm_guard_dp.sv
module hm_guard_dp
  import hm_guard_pkg::*;
#(
  parameter int unsigned HAW   = 39,
  parameter int unsigned ALIGN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  hmStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              statusQ,
  input  logic              dmaValid,
  input  logic [DATA_W-1:0] dmaAddr,
  output logic [DATA_W-1:0] startQ,
  output logic [DATA_W-1:0] endQ,
  output logic              dmaBlocked
);
  localparam logic [DATA_W-1:0] IMPL_MASK  = (DATA_W'(1) << HAW) - DATA_W'(1);
  localparam logic [DATA_W-1:0] LOW_ONES   = (DATA_W'(1) << ALIGN) - DATA_W'(1);
  localparam logic [DATA_W-1:0] FIELD_MASK = IMPL_MASK & ~LOW_ONES;

  logic [DATA_W-1:0] addrImpl;
  logic [DATA_W-1:0] endInclusive;
  logic              windowOn;
  logic              hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      endQ   <= '0;
    end else begin
      if (strb.wrStart) startQ <= wdata & FIELD_MASK;
      if (strb.wrEnd)   endQ   <= wdata & FIELD_MASK;
    end
  end

  assign addrImpl     = dmaAddr & IMPL_MASK;
  assign endInclusive = endQ | LOW_ONES;
  assign windowOn     = statusQ && (startQ <= endQ);
  assign hit          = windowOn && (addrImpl >= startQ) && (addrImpl <= endInclusive);

  always_ff @(posedge clk) begin
    if (!rstN) dmaBlocked <= 1'b0;
    else       dmaBlocked <= dmaValid && hit;
  end
endmodule

// File: rtl/hm_guard.sv
module hm_guard
  import hm_guard_pkg::*;
#(
  parameter int unsigned HAW   = 39,
  parameter int unsigned ALIGN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [OFS_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              capHigh,
  input  logic              dmaValid,
  input  logic [DATA_W-1:0] dmaAddr,
  output logic              dmaBlocked
);
  hmStrobe_t         strb;
  logic              enableQ;
  logic              statusQ;
  logic [DATA_W-1:0] startQ;
  logic [DATA_W-1:0] endQ;

  hm_guard_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .wrBit0  (regWdata[0]),
    .capHigh (capHigh),
    .strb    (strb),
    .enableQ (enableQ),
    .statusQ (statusQ)
  );

  hm_guard_dp #(.HAW(HAW), .ALIGN(ALIGN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (regWdata),
    .statusQ    (statusQ),
    .dmaValid   (dmaValid),
    .dmaAddr    (dmaAddr),
    .startQ     (startQ),
    .endQ       (endQ),
    .dmaBlocked (dmaBlocked)
  );

  always_comb begin
    unique case (regAddr)
      OFS_CTRL:  regRdata = {{(DATA_W-2){1'b0}}, statusQ, enableQ};
      OFS_START: regRdata = startQ;
      OFS_END:   regRdata = endQ;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/hm_guard_chk.sv
module hm_guard_chk
  import hm_guard_pkg::*;
#(
  parameter int unsigned HAW   = 39,
  parameter int unsigned ALIGN = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [OFS_W-1:0]  regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              capHigh,
  input logic              dmaValid,
  input logic              dmaBlocked,
  input logic              enableQ,
  input logic              statusQ,
  input logic [DATA_W-1:0] startQ,
  input logic [DATA_W-1:0] endQ
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    ((DATA_W'(1) << HAW) - DATA_W'(1)) & ~((DATA_W'(1) << ALIGN) - DATA_W'(1));

  p_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_START || regAddr == OFS_END) |-> ((regRdata & ~FIELD_MASK) == '0));

  p_status_lag_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusQ == $past(enableQ)));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && statusQ) |=> ($stable(startQ) && $stable(endQ)));

  p_cap_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !capHigh) |=> ($stable(startQ) && $stable(endQ)));

  p_needs_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    dmaBlocked |-> $past(statusQ));

  p_inverted_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && (startQ > endQ)) |=> !dmaBlocked);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dmaValid |=> !dmaBlocked);
endmodule

bind hm_guard hm_guard_chk #(.HAW(HAW), .ALIGN(ALIGN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regRdata   (regRdata),
  .capHigh    (capHigh),
  .dmaValid   (dmaValid),
  .dmaBlocked (dmaBlocked),
  .enableQ    (enableQ),
  .statusQ    (statusQ),
  .startQ     (startQ),
  .endQ       (endQ)
);

// File: tb/hm_guard_tb.sv
`timescale 1ns/1ps
module hm_guard_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        capHigh = 1'b1;
  logic        dmaValid = 1'b0;
  logic [63:0] dmaAddr = '0;
  logic        dmaBlocked;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hm_guard u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .capHigh(capHigh),
    .dmaValid(dmaValid), .dmaAddr(dmaAddr), .dmaBlocked(dmaBlocked)
  );

  // {expected blocked, address} for start 0x12_3400_0000, end 0x12_3450_0000
  localparam logic [64:0] VEC [8] = '{
    {1'b0, 64'h0000_0012_33FF_FFFF},
    {1'b1, 64'h0000_0012_3400_0000},
    {1'b1, 64'h0000_0012_3420_1234},
    {1'b1, 64'h0000_0012_345F_FFFF},
    {1'b0, 64'h0000_0012_3460_0000},
    {1'b1, 64'hFFFF_FF92_3430_0000},
    {1'b0, 64'h0000_0000_0000_0000},
    {1'b0, 64'hFFFF_FF80_0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic regCheck(input string req, input logic [7:0] a, input logic [63:0] exp);
    regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic probe(input string req, input logic [63:0] a, input logic exp);
    @(negedge clk);
    dmaValid = 1'b1; dmaAddr = a;
    @(negedge clk);
    dmaValid = 1'b0;
    check(req, {63'd0, dmaBlocked}, {63'd0, exp});
    @(negedge clk);
    check("R9", {63'd0, dmaBlocked}, 64'd0);
  endtask

  task automatic setEnable(input logic en);
    regWrite(8'h00, {63'd0, en});
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regCheck("R1", 8'h00, 64'd0);
    regCheck("R1", 8'h08, 64'd0);
    regCheck("R1", 8'h10, 64'd0);
    check("R1", {63'd0, dmaBlocked}, 64'd0);

    // R5 capability lock
    capHigh = 1'b0;
    regWrite(8'h08, 64'h0000_0012_3400_0000);
    regWrite(8'h10, 64'h0000_0012_3450_0000);
    regCheck("R5", 8'h08, 64'd0);
    regCheck("R5", 8'h10, 64'd0);
    capHigh = 1'b1;

    // R2 field masking
    regWrite(8'h08, 64'hFFFF_FF92_3401_2345);
    regWrite(8'h10, 64'hFFFF_FF12_3450_ABCD);
    regCheck("R2", 8'h08, 64'h0000_0012_3400_0000);
    regCheck("R2", 8'h10, 64'h0000_0012_3450_0000);

    // R6 nothing blocked while protection off
    probe("R6", 64'h0000_0012_3400_0000, 1'b0);

    // R3 status lags enable by one cycle
    regWrite(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    regCheck("R3", 8'h00, 64'd1);
    @(negedge clk);
    regCheck("R3", 8'h00, 64'd3);

    // R6 window sweep
    for (int i = 0; i < 8; i++) probe("R6", VEC[i][63:0], VEC[i][64]);

    // R4 freeze while protecting
    regWrite(8'h08, 64'h0000_0001_0000_0000);
    regWrite(8'h10, 64'h0000_0002_0000_0000);
    regCheck("R4", 8'h08, 64'h0000_0012_3400_0000);
    regCheck("R4", 8'h10, 64'h0000_0012_3450_0000);

    // R7 inverted window
    setEnable(1'b0);
    regWrite(8'h10, 64'h0000_0012_3300_0000);
    regCheck("R7", 8'h10, 64'h0000_0012_3300_0000);
    setEnable(1'b1);
    probe("R7", 64'h0000_0012_3400_0000, 1'b0);
    probe("R7", 64'h0000_0012_3300_0000, 1'b0);
    probe("R7", 64'h0000_0012_33FF_FFFF, 1'b0);

    // R8 equal fields give one 1 MiB block
    setEnable(1'b0);
    regWrite(8'h10, 64'h0000_0012_3400_0000);
    setEnable(1'b1);
    probe("R8", 64'h0000_0012_33FF_FFFF, 1'b0);
    probe("R8", 64'h0000_0012_3400_0000, 1'b1);
    probe("R8", 64'h0000_0012_340F_FFFF, 1'b1);
    probe("R8", 64'h0000_0012_3410_0000, 1'b0);

    // R10 unmapped offset
    setEnable(1'b0);
    regWrite(8'h18, 64'h0000_0001_0000_0000);
    regCheck("R10", 8'h18, 64'd0);
    regCheck("R10", 8'h08, 64'h0000_0012_3400_0000);
    regCheck("R10", 8'h10, 64'h0000_0012_3400_0000);
    regCheck("R10", 8'h00, 64'd0);

    finishRun();
  end
endmodule